// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

Two up-counting interval timers, each holding a compare value. A timer counts the events of its own source: the shared clock-enable tick, or rising edges of an external count clock. When a running timer's count equals its compare value, the next event returns the count to zero. At that event the timer also raises a one-cycle interrupt pulse and flips its output pin. Each timer can run continuously or stop itself after its first match. It is started and stopped by software command strobes or by rising edges on a shared trigger input.

Setting the cascade input joins the two timers into one 16-bit timer. Timer 0 is the low byte and timer 1 is the high byte. Only timer 1's controls, interrupt and output pin are active in this mode. The block sits behind a register interface that drives its compare, mode and command inputs. It feeds an interrupt controller and a pin multiplexer.

Top module: `timer_pair`

## Requirements
- R1: After reset both counters are zero, and `irq`, `togOut` and `running` are all low.
- R2: A running channel with compare value P in independent mode raises `irq` for one cycle once every P+1 count events, and its counter returns to zero at the matching event.
- R3: Bit i of `clkSel` picks the count source of channel i: 0 selects `tick`, 1 selects rising edges of `extClk`. Events of the unselected source do not advance the channel.
- R4: With its `oneShot` bit set, a channel clears `running` at its first match, in the same cycle that `irq` rises, and produces no further interrupt.
- R5: With `cascade` high, the pair counts as one 16-bit timer with compare value {period1, period0} and with channel 1's source, mode and commands. Its interrupt appears on `irq[1]` once every {period1, period0}+1 events. `irq[0]` stays low and `running[0]` stays low.
- R6: `togOut[i]` flips exactly when `irq[i]` is raised. In cascade mode `togOut[0]` holds its value.
- R7: A `swStart` pulse to an idle channel sets `running` and clears the counter, so the first interrupt comes P+1 events later. A `swStop` pulse clears `running`. When both arrive in the same cycle, the stop wins. A start to a running channel has no effect.
- R8: A rising edge on `trig` starts an idle channel whose `trigStartEn` bit is set, and stops a running channel whose `trigStopEn` bit is set. A channel with neither condition met ignores the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable |
| extClk | input | 1 | External count clock, counted on rising edges |
| clkSel | input | 2 | Per-channel source select (1 = extClk) |
| cascade | input | 1 | Join both channels into one 16-bit timer |
| oneShot | input | 2 | Per-channel one-shot mode |
| swStart | input | 2 | Per-channel software start strobe |
| swStop | input | 2 | Per-channel software stop strobe |
| trig | input | 1 | External trigger, rising edge active |
| trigStartEn | input | 2 | Trigger edge starts an idle channel |
| trigStopEn | input | 2 | Trigger edge stops a running channel |
| period0 | input | W | Compare value of channel 0 (low byte in cascade) |
| period1 | input | W | Compare value of channel 1 (high byte in cascade) |
| irq | output | 2 | One-cycle match interrupt per channel |
| togOut | output | 2 | Output pin per channel, flips on each match |
| running | output | 2 | Run flag per channel |

## Verification
The bench sweeps the compare value of both channels at once. Channel 0 steps through 0 to 15 while channel 1 steps through multiples of 17 up to 255. This separates off-by-one wrap errors from compare errors at the extremes.

The same interval measurement is then repeated with a tick every third cycle and with the external clock as source. A wrong period is then told apart from a wrong event source, and a channel with no ticks must stay silent. Cascade runs use 16-bit compare values of 0, 3, 255, 256 and 291, so that a missed or doubled carry at the byte boundary shows up as an interval error.

Directed sequences cover the remaining control paths: one-shot termination, start clearing a partly advanced count, stop beating start, and trigger edges with each enable combination.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] cntEn;   // count event for each channel (cascade: bit 0 drives the pair)
    logic [1:0] clr;     // clear counter on start from idle
    logic       cascade; // 16-bit mode
  } tpStrobe_t;
endpackage

// File: rtl/timer_pair_ctrl.sv
module timer_pair_ctrl
  import timer_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       extClk,
  input  logic [1:0] clkSel,
  input  logic       cascade,
  input  logic [1:0] oneShot,
  input  logic [1:0] swStart,
  input  logic [1:0] swStop,
  input  logic       trig,
  input  logic [1:0] trigStartEn,
  input  logic [1:0] trigStopEn,
  input  logic [1:0] match,
  output tpStrobe_t  strobe,
  output logic [1:0] running
);
  logic       extPrev, trigPrev;
  logic       extRise, trigRise;
  logic [1:0] evt, startReq, stopReq, active, clrRaw, runQ, runD;

  assign extRise  = extClk & ~extPrev;
  assign trigRise = trig & ~trigPrev;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    // in cascade mode channel 0 is slaved to channel 1
    assign active[i]   = (i == 0) ? ~cascade : 1'b1;
    assign evt[i]      = clkSel[i] ? extRise : tick;
    assign startReq[i] = swStart[i] | (trigRise & trigStartEn[i] & ~runQ[i]);
    assign stopReq[i]  = swStop[i]  | (trigRise & trigStopEn[i]  &  runQ[i]);
    assign clrRaw[i]   = active[i] & ~runQ[i] & startReq[i] & ~stopReq[i];
    assign runD[i] = !active[i]                          ? 1'b0 :
                     stopReq[i]                          ? 1'b0 :
                     (!runQ[i] && startReq[i])           ? 1'b1 :
                     (runQ[i] && oneShot[i] && match[i]) ? 1'b0 :
                                                           runQ[i];

    p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
      swStop[i] |=> !runQ[i]);
    p_oneshot_end_r4: assert property (@(posedge clk) disable iff (!rstN)
      (runQ[i] && oneShot[i] && match[i] && !swStart[i]) |=> !runQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev  <= 1'b0;
      trigPrev <= 1'b0;
      runQ     <= '0;
    end else begin
      extPrev  <= extClk;
      trigPrev <= trig;
      runQ     <= runD;
    end
  end

  assign strobe.cascade = cascade;
  assign strobe.cntEn   = cascade ? {1'b0, runQ[1] & evt[1]} : (runQ & evt);
  assign strobe.clr     = cascade ? {clrRaw[1], clrRaw[1]} : clrRaw;
  assign running        = runQ;

  p_casc_low_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    cascade |=> !runQ[0]);
endmodule

// File: rtl/timer_pair_dp.sv
module timer_pair_dp
  import timer_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  tpStrobe_t    strobe,
  input  logic [W-1:0] period0,
  input  logic [W-1:0] period1,
  output logic [1:0]   match,
  output logic [1:0]   irq,
  output logic [1:0]   togOut
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt0, cnt1, cnt0D, cnt1D;
  logic         hitLo, hitHi, hitWide, anyClr;
  logic [1:0]   irqQ, togQ;

  always_comb begin
    hitLo   = strobe.cntEn[0] && (cnt0 == period0);
    hitHi   = strobe.cntEn[1] && (cnt1 == period1);
    hitWide = strobe.cntEn[0] && (cnt0 == period0) && (cnt1 == period1);
    match   = strobe.cascade ? {hitWide, 1'b0} : {hitHi, hitLo};
    anyClr  = strobe.clr[0] | strobe.clr[1];
    cnt0D   = cnt0;
    cnt1D   = cnt1;
    if (strobe.cascade) begin
      if (anyClr || hitWide) begin
        cnt0D = '0;
        cnt1D = '0;
      end else if (strobe.cntEn[0]) begin
        cnt0D = cnt0 + ONE;
        if (cnt0 == TOP) cnt1D = cnt1 + ONE;  // low byte carry
      end
    end else begin
      if (strobe.clr[0] || hitLo)  cnt0D = '0;
      else if (strobe.cntEn[0])    cnt0D = cnt0 + ONE;
      if (strobe.clr[1] || hitHi)  cnt1D = '0;
      else if (strobe.cntEn[1])    cnt1D = cnt1 + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt0 <= '0;
      cnt1 <= '0;
      irqQ <= '0;
      togQ <= '0;
    end else begin
      cnt0 <= cnt0D;
      cnt1 <= cnt1D;
      irqQ <= match;
      togQ <= togQ ^ match;
    end
  end

  assign irq    = irqQ;
  assign togOut = togQ;

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cascade && hitLo) |=> (cnt0 == '0));
  p_wide_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cascade && hitWide) |=> (cnt0 == '0 && cnt1 == '0));
  p_casc_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cascade |=> !irqQ[0]);

  for (genvar i = 0; i < 2; i++) begin : g_tog
    p_tog_with_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
      (togQ[i] != $past(togQ[i])) |-> irqQ[i]);
  end
endmodule

// File: rtl/timer_pair.sv
module timer_pair
  import timer_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         extClk,
  input  logic [1:0]   clkSel,
  input  logic         cascade,
  input  logic [1:0]   oneShot,
  input  logic [1:0]   swStart,
  input  logic [1:0]   swStop,
  input  logic         trig,
  input  logic [1:0]   trigStartEn,
  input  logic [1:0]   trigStopEn,
  input  logic [W-1:0] period0,
  input  logic [W-1:0] period1,
  output logic [1:0]   irq,
  output logic [1:0]   togOut,
  output logic [1:0]   running
);
  tpStrobe_t  strobe;
  logic [1:0] match;

  timer_pair_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .extClk(extClk), .clkSel(clkSel),
    .cascade(cascade), .oneShot(oneShot), .swStart(swStart), .swStop(swStop),
    .trig(trig), .trigStartEn(trigStartEn), .trigStopEn(trigStopEn),
    .match(match), .strobe(strobe), .running(running)
  );

  timer_pair_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period0(period0),
    .period1(period1), .match(match), .irq(irq), .togOut(togOut)
  );
endmodule

// File: tb/timer_pair_bench.sv
module timer_pair_bench;
  logic       clk = 1'b0, rstN = 1'b0, tick = 1'b0, extClk = 1'b0;
  logic       cascade = 1'b0, trig = 1'b0;
  logic [1:0] clkSel = '0, oneShot = '0, swStart = '0, swStop = '0;
  logic [1:0] trigStartEn = '0, trigStopEn = '0;
  logic [7:0] period0 = '0, period1 = '0;
  wire  [1:0] irq, togOut, running;

  int tests = 0, fails = 0, cyc = 0;
  int tickDiv = 1, tickCnt = 0, extHalf = 0, extCnt = 0;
  bit irq0Seen = 1'b0;

  timer_pair u_timer_pair (
    .clk(clk), .rstN(rstN), .tick(tick), .extClk(extClk), .clkSel(clkSel),
    .cascade(cascade), .oneShot(oneShot), .swStart(swStart), .swStop(swStop),
    .trig(trig), .trigStartEn(trigStartEn), .trigStopEn(trigStopEn),
    .period0(period0), .period1(period1), .irq(irq), .togOut(togOut),
    .running(running)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tick and external clock generation, driven away from the active edge
  always @(negedge clk) begin
    if (tickDiv == 0) tick <= 1'b0;
    else begin
      tick    <= (tickCnt == 0);
      tickCnt <= (tickCnt + 1 >= tickDiv) ? 0 : tickCnt + 1;
    end
    if (extHalf != 0) begin
      if (extCnt + 1 >= extHalf) begin extCnt <= 0; extClk <= ~extClk; end
      else extCnt <= extCnt + 1;
    end
    if (irq[0]) irq0Seen <= 1'b1;
  end

  task automatic check(bit cond, string tag, int act, int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic findIrq(int ch, output int when, output bit ok);
    ok = 1'b0; when = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (irq[ch]) begin when = cyc; ok = 1'b1; break; end
    end
  endtask

  task automatic measure(int ch, int exp, string tag);
    int t1, t2; bit ok1, ok2; logic tg;
    findIrq(ch, t1, ok1);
    tg = togOut[ch];
    findIrq(ch, t2, ok2);
    check(ok1 && ok2 && (t2 - t1 == exp), tag, t2 - t1, exp);
    check(togOut[ch] != tg, "R6 toggle on match", int'(togOut[ch]), int'(~tg));
  endtask

  task automatic pulseStart(logic [1:0] m);
    @(negedge clk); swStart = m;
    @(negedge clk); swStart = '0;
  endtask

  task automatic pulseStop(logic [1:0] m);
    @(negedge clk); swStop = m;
    @(negedge clk); swStop = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t1, c0, n; bit ok; logic tg0;
    int casc[5] = '{0, 3, 255, 256, 291};
    int slow[3] = '{0, 2, 7};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq == 2'b00, "R1 irq after reset", int'(irq), 0);
    check(togOut == 2'b00, "R1 togOut after reset", int'(togOut), 0);
    check(running == 2'b00, "R1 running after reset", int'(running), 0);

    // R2 continuous sweep on both channels together
    for (int p = 0; p < 16; p++) begin
      pulseStop(2'b11);
      period0 = 8'(p);
      period1 = 8'(p * 17);
      pulseStart(2'b11);
      measure(0, p + 1, "R2 ch0 interval");
      measure(1, p * 17 + 1, "R2 ch1 interval");
    end

    // R7 start from idle clears a partly advanced count
    pulseStop(2'b11);
    period0 = 8'd5;
    pulseStart(2'b01);
    repeat (3) @(negedge clk);
    pulseStop(2'b01);
    @(negedge clk); swStart = 2'b01; c0 = cyc;
    @(negedge clk); swStart = '0;
    check(running[0] == 1'b1, "R7 running after start", int'(running[0]), 1);
    findIrq(0, t1, ok);
    check(ok && (t1 - c0 == 7), "R7 first match after start", t1 - c0, 7);
    pulseStop(2'b01);
    check(running[0] == 1'b0, "R7 stop clears running", int'(running[0]), 0);
    @(negedge clk); swStart = 2'b01; swStop = 2'b01;
    @(negedge clk); swStart = '0; swStop = '0;
    check(running[0] == 1'b0, "R7 stop wins over start", int'(running[0]), 0);

    // R3 tick every third cycle
    tickDiv = 3;
    foreach (slow[k]) begin
      pulseStop(2'b01);
      period0 = 8'(slow[k]);
      pulseStart(2'b01);
      measure(0, 3 * (slow[k] + 1), "R3 divided tick interval");
    end
    // R3 external source on channel 1, channel 0 on a silent tick
    pulseStop(2'b11);
    tickDiv = 0; clkSel = 2'b10; extHalf = 4; period0 = 8'd0;
    for (int p = 1; p <= 3; p += 2) begin
      pulseStop(2'b11);
      period1 = 8'(p);
      pulseStart(2'b11);
      @(negedge clk); irq0Seen = 1'b0;
      measure(1, 8 * (p + 1), "R3 external clock interval");
      check(irq0Seen == 1'b0, "R3 channel without ticks stays idle", int'(irq0Seen), 0);
    end
    pulseStop(2'b11);
    extHalf = 0; clkSel = 2'b00; tickDiv = 1;

    // R4 one-shot
    oneShot = 2'b01; period0 = 8'd4;
    pulseStart(2'b01);
    findIrq(0, t1, ok);
    check(ok && running[0] == 1'b0, "R4 run clears at match", int'(running[0]), 0);
    n = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (irq[0]) n++; end
    check(n == 0, "R4 no further interrupts", n, 0);
    oneShot = 2'b00;

    // R5 cascade
    pulseStop(2'b11);
    cascade = 1'b1;
    foreach (casc[k]) begin
      period1 = 8'(casc[k] >> 8);
      period0 = 8'(casc[k] & 255);
      pulseStart(2'b10);
      @(negedge clk); irq0Seen = 1'b0; tg0 = togOut[0];
      measure(1, casc[k] + 1, "R5 16-bit interval");
      check(irq0Seen == 1'b0, "R5 low interrupt suppressed", int'(irq0Seen), 0);
      check(running[0] == 1'b0, "R5 low run flag idle", int'(running[0]), 0);
      check(togOut[0] == tg0, "R6 low output holds in cascade", int'(togOut[0]), int'(tg0));
      pulseStop(2'b10);
    end
    cascade = 1'b0;

    // R8 trigger start and stop
    pulseStop(2'b11);
    period0 = 8'd50; period1 = 8'd50;
    trigStartEn = 2'b01;
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    check(running[0] == 1'b1, "R8 trigger starts enabled channel", int'(running[0]), 1);
    check(running[1] == 1'b0, "R8 disabled channel ignores trigger", int'(running[1]), 0);
    trig = 1'b0; trigStartEn = 2'b00; trigStopEn = 2'b01;
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    check(running[0] == 1'b0, "R8 trigger stops running channel", int'(running[0]), 0);
    trig = 1'b0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    check(running[0] == 1'b0, "R8 stop-only trigger leaves idle channel", int'(running[0]), 0);
    trig = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule